// File: doc/BRIEF.md
# Vector Configuration and Length-Setting Unit

This block performs the configuration step of an instruction that sets the vector length. On a valid strobe it takes the source and destination register specifiers, the requested application vector length, an element-width code and a 3-bit group-multiplier selector. From these it computes a new configuration word and a granted vector length, and latches both on the next clock edge. The configuration word holds a multiplier field, a 3-bit alternate-mode field and an illegal flag.

The alternate-mode code is not taken from an immediate. It comes from the register specifiers. It is non-zero only when the two specifiers differ and share their two low bits, and in that case it equals the top three bits of the destination specifier. Alternate mode 001 turns the four large selectors into the multipliers 3, 5, 6 and 7. These are used for the length computation and are written back rounded up to 4 or 8. As a result, the register group keeps a 4-register or 8-register alignment, and the effective multiplier is not stored.

Top module: `vcfg_len_unit`

## Requirements
- R1: When `src_spec[1:0]` differs from `dst_spec[1:0]`, the alternate-mode code is 000.
- R2: When `src_spec` equals `dst_spec`, the alternate-mode code is 000.
- R3: Otherwise the alternate-mode code is `dst_spec[4:2]`. Code 000 is normal mode, 001 is alternate mode, and 010 to 111 are reserved and set `cfg_ill`. A legal result shows the code on `cfg_alt`.
- R4: Selector 000 is reserved in both modes and sets `cfg_ill`. In normal mode the selectors 001 to 111 mean multipliers 1/8, 1/4, 1/2, 1, 2, 4 and 8, and each selector is written back unchanged on `cfg_lmul`.
- R5: In alternate mode the selectors 001, 010 and 011 keep their normal meaning and are written back unchanged. Selector 100 gives an effective multiplier of 3 and writes back 110. Selectors 101, 110 and 111 give 5, 6 and 7 and write back 111.
- R6: The maximum length is floor(VLEN × effective multiplier / SEW), where `sew_code` 00, 01, 10 and 11 mean SEW of 8, 16, 32 and 64 bits.
- R7: The granted length `vl` is the smaller of `avl` and the maximum length.
- R8: On an illegal configuration, `cfg_ill` is 1 and `vl`, `cfg_lmul` and `cfg_alt` are 0.
- R9: The outputs change only on the clock edge after a cycle with `valid` high. `done` is high for exactly the cycle after each such strobe, and the outputs hold otherwise.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Strobe that requests a configuration update |
| src_spec | input | 5 | Source register specifier |
| dst_spec | input | 5 | Destination register specifier |
| avl | input | AVL_W | Requested application vector length |
| sew_code | input | 2 | Element width code (8 << code bits) |
| lmul_sel | input | 3 | Group-multiplier selector |
| cfg_lmul | output | 3 | Multiplier field written back |
| cfg_alt | output | 3 | Alternate-mode field |
| cfg_ill | output | 1 | Illegal configuration flag |
| vl | output | AVL_W | Granted vector length |
| done | output | 1 | One-cycle pulse with new outputs |

## Verification
The assertions check on every cycle that an illegal result clears every other field, and that `done` follows the strobe by exactly one cycle. They also check that outputs hold without a strobe, that the granted length never exceeds the request, and that alternate mode never writes back the selectors 000, 100 or 101. Only the bench scenarios can show the exact arithmetic for each non-power-of-two multiplier, the truncation of fractional results to zero, the zeroing rules for mismatched or identical specifiers, and the reserved-code decode. The bench compares each of these against hand-computed values.

// File: rtl/vcfg_len_unit.sv
module vcfg_len_unit #(
  parameter int VLEN  = 128,
  parameter int AVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [4:0]       src_spec,
  input  logic [4:0]       dst_spec,
  input  logic [AVL_W-1:0] avl,
  input  logic [1:0]       sew_code,
  input  logic [2:0]       lmul_sel,
  output logic [2:0]       cfg_lmul,
  output logic [2:0]       cfg_alt,
  output logic             cfg_ill,
  output logic [AVL_W-1:0] vl,
  output logic             done
);
  localparam int VB = $clog2(VLEN) + 1;
  localparam int PW = VB + 7;
  localparam int CW = (AVL_W > PW) ? AVL_W : PW;

  logic [2:0]    alt_code;
  logic          alt_on, bad;
  logic [6:0]    eighths;
  logic [2:0]    wb_lmul;
  logic [PW-1:0] prod, maxlen;
  logic [CW-1:0] avl_x, max_x, vl_x;

  // Decode the alternate-mode code from the two specifiers (R1, R2, R3).
  assign alt_code = (src_spec[1:0] != dst_spec[1:0] || src_spec == dst_spec) ? 3'd0 : dst_spec[4:2];
  assign alt_on   = (alt_code == 3'd1);
  assign bad      = (alt_code > 3'd1) || (lmul_sel == 3'd0);

  // Effective multiplier in units of 1/8 (R4, R5).
  always_comb begin
    case (lmul_sel)
      3'd1:    eighths = 7'd1;
      3'd2:    eighths = 7'd2;
      3'd3:    eighths = 7'd4;
      3'd4:    eighths = alt_on ? 7'd24 : 7'd8;
      3'd5:    eighths = alt_on ? 7'd40 : 7'd16;
      3'd6:    eighths = alt_on ? 7'd48 : 7'd32;
      3'd7:    eighths = alt_on ? 7'd56 : 7'd64;
      default: eighths = 7'd0;
    endcase
  end

  // Written-back field, rounded up to 4 or 8 in alternate mode.
  assign wb_lmul = (alt_on && lmul_sel[2]) ? ((lmul_sel == 3'd4) ? 3'd6 : 3'd7) : lmul_sel;

  // Shift-and-add product of VLEN and the multiplier (R6).
  always_comb begin
    prod = '0;
    for (int i = 0; i < 7; i++)
      if (eighths[i]) prod = prod + (PW'(VLEN) << i);
  end

  // Divide by 8 (to undo the 1/8 unit) and by SEW = 8 << sew_code.
  assign maxlen = prod >> (4'd6 + {2'b00, sew_code});
  assign avl_x  = CW'(avl);
  assign max_x  = CW'(maxlen);
  assign vl_x   = (avl_x < max_x) ? avl_x : max_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lmul <= '0;
      cfg_alt  <= '0;
      cfg_ill  <= 1'b0;
      vl       <= '0;
      done     <= 1'b0;
    end else begin
      done <= valid;
      if (valid) begin
        cfg_ill  <= bad;
        cfg_lmul <= bad ? 3'd0 : wb_lmul;
        cfg_alt  <= bad ? 3'd0 : alt_code;
        vl       <= bad ? '0 : vl_x[AVL_W-1:0];
      end
    end
  end

  a_r8_ill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ill |-> (vl == '0 && cfg_lmul == 3'd0 && cfg_alt == 3'd0));

  a_r9_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> done);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!done && $stable(vl) && $stable(cfg_lmul) && $stable(cfg_alt) && $stable(cfg_ill)));

  a_r7_vl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (vl <= $past(avl)));

  a_r5_alt_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ill && cfg_alt == 3'd1) |-> (cfg_lmul != 3'd0 && cfg_lmul != 3'd4 && cfg_lmul != 3'd5));

  a_r3_alt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ill |-> (cfg_alt <= 3'd1));
endmodule

// File: tb/vcfg_len_unit_test.sv
module vcfg_len_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  src_spec = '0, dst_spec = '0;
  logic [15:0] avl = '0;
  logic [1:0]  sew_code = '0;
  logic [2:0]  lmul_sel = '0;
  logic [2:0]  cfg_lmul, cfg_alt;
  logic        cfg_ill, done;
  logic [15:0] vl;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  vcfg_len_unit #(.VLEN(128), .AVL_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .src_spec(src_spec), .dst_spec(dst_spec),
    .avl(avl), .sew_code(sew_code), .lmul_sel(lmul_sel), .cfg_lmul(cfg_lmul),
    .cfg_alt(cfg_alt), .cfg_ill(cfg_ill), .vl(vl), .done(done));

  // {src, dst, avl, sew, sel, exp_lmul, exp_alt, exp_ill, exp_vl}, VLEN = 128
  localparam int N = 16;
  localparam logic [53:0] VEC [N] = '{
    {5'd1, 5'd5,  16'd100,  2'd0, 3'd4, 3'd6, 3'd1, 1'b0, 16'd48},
    {5'd1, 5'd5,  16'd1000, 2'd1, 3'd5, 3'd7, 3'd1, 1'b0, 16'd40},
    {5'd2, 5'd6,  16'd24,   2'd2, 3'd6, 3'd7, 3'd1, 1'b0, 16'd24},
    {5'd3, 5'd7,  16'd50,   2'd0, 3'd7, 3'd7, 3'd1, 1'b0, 16'd50},
    {5'd1, 5'd5,  16'd10,   2'd0, 3'd0, 3'd0, 3'd0, 1'b1, 16'd0},
    {5'd1, 5'd5,  16'd10,   2'd0, 3'd1, 3'd1, 3'd1, 1'b0, 16'd2},
    {5'd1, 5'd6,  16'd100,  2'd0, 3'd4, 3'd4, 3'd0, 1'b0, 16'd16},
    {5'd5, 5'd5,  16'd40,   2'd0, 3'd5, 3'd5, 3'd0, 1'b0, 16'd32},
    {5'd0, 5'd8,  16'd40,   2'd0, 3'd4, 3'd0, 3'd0, 1'b1, 16'd0},
    {5'd3, 5'd31, 16'd40,   2'd0, 3'd4, 3'd0, 3'd0, 1'b1, 16'd0},
    {5'd4, 5'd0,  16'd17,   2'd3, 3'd7, 3'd7, 3'd0, 1'b0, 16'd16},
    {5'd4, 5'd0,  16'd5,    2'd3, 3'd3, 3'd3, 3'd0, 1'b0, 16'd1},
    {5'd4, 5'd0,  16'd5,    2'd3, 3'd1, 3'd1, 3'd0, 1'b0, 16'd0},
    {5'd1, 5'd5,  16'd0,    2'd1, 3'd3, 3'd3, 3'd1, 1'b0, 16'd0},
    {5'd4, 5'd0,  16'd9,    2'd0, 3'd0, 3'd0, 3'd0, 1'b1, 16'd0},
    {5'd1, 5'd5,  16'd3,    2'd2, 3'd2, 3'd2, 3'd1, 1'b0, 16'd1}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2, 3: return "R5/R6 alt multipliers 3,5,6,7";
      4, 14:      return "R4/R8 reserved selector";
      5, 15:      return "R5 alt fractional selector";
      6:          return "R1 low bits differ";
      7:          return "R2 identical specifiers";
      8, 9:       return "R3/R8 reserved alt code";
      10, 11, 12: return "R6 normal multiplier and truncation";
      default:    return "R7 zero request";
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] s, input logic [4:0] d, input logic [15:0] a,
                       input logic [1:0] w, input logic [2:0] m);
    @(negedge clk);
    src_spec = s; dst_spec = d; avl = a; sew_code = w; lmul_sel = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset vl", 32'(vl), 0);
    chk("R10 reset fields", {26'd0, cfg_lmul, cfg_alt}, 0);
    chk("R10 reset flags", {30'd0, cfg_ill, done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      apply(VEC[i][53:49], VEC[i][48:44], VEC[i][43:28], VEC[i][27:26], VEC[i][25:23]);
      chk({tag_of(i), " lmul"}, 32'(cfg_lmul), 32'(VEC[i][22:20]));
      chk({tag_of(i), " alt"},  32'(cfg_alt),  32'(VEC[i][19:17]));
      chk({tag_of(i), " ill"},  32'(cfg_ill),  32'(VEC[i][16]));
      chk({tag_of(i), " vl"},   32'(vl),       32'(VEC[i][15:0]));
      chk("R9 done pulse", 32'(done), 1);
    end

    // R9: without a strobe, changed inputs leave the outputs unchanged and done drops
    src_spec = 5'd1; dst_spec = 5'd5; avl = 16'd999; sew_code = 2'd0; lmul_sel = 3'd7;
    @(negedge clk);
    chk("R9 done low without strobe", 32'(done), 0);
    @(negedge clk);
    chk("R9 vl held", 32'(vl), 1);
    chk("R9 lmul held", 32'(cfg_lmul), 2);

    // R7: request exactly one above the maximum (128*7/8 = 112)
    apply(5'd1, 5'd5, 16'd113, 2'd0, 3'd7);
    chk("R7 clamp to max", 32'(vl), 112);

    // R8 then recovery: an illegal result followed by a legal one
    apply(5'd2, 5'd10, 16'd50, 2'd0, 3'd4);
    chk("R8 ill set", 32'(cfg_ill), 1);
    chk("R8 vl cleared", 32'(vl), 0);
    apply(5'd2, 5'd6, 16'd50, 2'd1, 3'd4);
    chk("R5 alt 3 at sew16 vl", 32'(vl), 24);
    chk("R8 ill cleared", 32'(cfg_ill), 0);

    // R1: destination x0 with different low bits stays normal
    apply(5'd7, 5'd0, 16'd500, 2'd0, 3'd6);
    chk("R1 normal lmul4 alt", 32'(cfg_alt), 0);
    chk("R1 normal lmul4 vl", 32'(vl), 64);

    // R10: reset during operation clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset mid-run", {cfg_lmul, cfg_alt, cfg_ill, done, vl}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule